// File: doc/BRIEF.md
# Prescaled Up-Counting Timer with Overflow Flag

This block is an 8-bit up-counter that advances once per prescaled tick, where the tick rate is the system clock divided by 2 raised to a build-time exponent. A small command port drives it the way a processor's timer instructions would. One command loads a full 8-bit start value. Two commands start and stop counting. Two more write either 4-bit half of the count. A read-select input picks which half appears on a 4-bit read port.

When a running count steps from FFH to 00H, the block sets a sticky timer flag and pulses an interrupt request for one cycle. Counting then carries on from 00H. The flag can be cleared in two ways: an interrupt acknowledge, or a test strobe that samples the flag and clears it. The second way serves a branch-on-flag instruction.

The prescaler exponent may be any value from 0 to 13 except 6. Any other value stops elaboration.

Top module: `pscale_timer`

## Requirements
- R1: While reset is asserted and after it is released, the count is 00H, the flag and the interrupt request are low, and the counter is stopped.
- R2: While running, the count increases by one on every prescaled tick, one tick every 2^DIV_EXP clock cycles, with the divider running freely from reset.
- R3: Command code 1 (load) puts data_i[7:0] into the count on the next clock edge, whatever the tick phase, and discards any pending nibble write.
- R4: Command code 2 starts counting and command code 3 stops it. A stopped count holds its value. A start takes effect from the following tick.
- R5: A tick that moves a running count from FFH to 00H sets the flag and raises irq_o for exactly one cycle. Counting goes on from 00H.
- R6: irq_ack_i high clears the flag on the next edge.
- R7: flag_test_i high clears the flag on the next edge. flag_o still shows the tested value during the strobe cycle.
- R8: When an overflow and a clear request (acknowledge or test) occur in the same cycle, the flag ends up set.
- R9: rd_nib_o shows count bits 7:4 when rd_hi_i is 1 and bits 3:0 when it is 0.
- R10: Command codes 4 (write low) and 5 (write high) take data_i[3:0]. The write lands on the next tick, running or not, and leaves the other nibble as it was. That tick does not increment.
- R11: Command code 0 and the unused codes 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Command code (0 none, 1 load, 2 start, 3 stop, 4 write low, 5 write high) |
| data_i | input | 8 | Load value, or nibble write value in bits 3:0 |
| rd_hi_i | input | 1 | Read-port select: 1 high nibble, 0 low nibble |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears the flag |
| flag_test_i | input | 1 | Test-and-clear strobe for the flag |
| count_o | output | 8 | Current count |
| rd_nib_o | output | 4 | Selected nibble of the count |
| flag_o | output | 1 | Sticky timer flag |
| irq_o | output | 1 | One-cycle interrupt request on overflow |

## Verification
The bench builds the timer with DIV_EXP = 2, so a tick comes every four cycles. With that setting, a full 256-step wrap takes about a thousand cycles, so several overflows fit in one short run. The bench can also place commands at every tick phase, including nibble writes and starts that coincide with a tick. Holding the acknowledge high across a wrap exercises the case where an overflow and a clear fall in the same cycle.

// File: rtl/pscale_timer_pkg.sv
package pscale_timer_pkg;
  typedef enum logic [2:0] {
    TC_NOP    = 3'd0,
    TC_LOAD   = 3'd1,
    TC_START  = 3'd2,
    TC_STOP   = 3'd3,
    TC_WR_LO  = 3'd4,
    TC_WR_HI  = 3'd5
  } tmr_cmd_e;
endpackage

// File: rtl/pscale_timer_div.sv
module pscale_timer_div #(
  parameter int DIV_EXP = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  if (DIV_EXP == 0) begin : g_nodiv
    assign tick_o = 1'b1;
  end else begin : g_div
    logic [DIV_EXP-1:0] pre_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pre_q <= '0;
      else         pre_q <= pre_q + 1'b1;
    end
    assign tick_o = &pre_q;
  end
endmodule

// File: rtl/pscale_timer_cnt.sv
module pscale_timer_cnt
  import pscale_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  tmr_cmd_e         cmd_i,
  input  logic [CNT_W-1:0] data_i,
  output logic [CNT_W-1:0] count_o,
  output logic             run_o,
  output logic             ovf_o
);
  localparam int NIB_W = CNT_W / 2;

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             plo_v_q, phi_v_q;
  logic [NIB_W-1:0] plo_q, phi_q;
  logic             pend_w;
  logic [CNT_W-1:0] merged_w;

  assign pend_w   = plo_v_q | phi_v_q;
  assign merged_w = {phi_v_q ? phi_q : cnt_q[CNT_W-1:NIB_W],
                     plo_v_q ? plo_q : cnt_q[NIB_W-1:0]};
  // rollover only on a plain increment tick
  assign ovf_o = (cmd_i != TC_LOAD) && tick_i && run_q && !pend_w && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      run_q   <= 1'b0;
      plo_v_q <= 1'b0;
      phi_v_q <= 1'b0;
      plo_q   <= '0;
      phi_q   <= '0;
    end else begin
      if (cmd_i == TC_START) run_q <= 1'b1;
      if (cmd_i == TC_STOP)  run_q <= 1'b0;
      if (cmd_i == TC_LOAD) begin
        cnt_q   <= data_i;
        plo_v_q <= 1'b0;
        phi_v_q <= 1'b0;
      end else begin
        if (tick_i && pend_w) begin
          cnt_q   <= merged_w;
          plo_v_q <= 1'b0;
          phi_v_q <= 1'b0;
        end else if (tick_i && run_q) begin
          cnt_q <= cnt_q + 1'b1;
        end
        // a write arriving on a tick waits for the following tick
        if (cmd_i == TC_WR_LO) begin
          plo_v_q <= 1'b1;
          plo_q   <= data_i[NIB_W-1:0];
        end
        if (cmd_i == TC_WR_HI) begin
          phi_v_q <= 1'b1;
          phi_q   <= data_i[NIB_W-1:0];
        end
      end
    end
  end

  assign count_o = cnt_q;
  assign run_o   = run_q;
endmodule

// File: rtl/pscale_timer_flag.sv
module pscale_timer_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovf_i,
  input  logic ack_i,
  input  logic test_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= ovf_i;
      if (ovf_i)                flag_q <= 1'b1;  // set beats clear
      else if (ack_i || test_i) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/pscale_timer.sv
module pscale_timer
  import pscale_timer_pkg::*;
#(
  parameter int DIV_EXP = 3,
  parameter int CNT_W   = 8,
  localparam int NIB_W  = CNT_W / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       cmd_i,
  input  logic [CNT_W-1:0] data_i,
  input  logic             rd_hi_i,
  input  logic             irq_ack_i,
  input  logic             flag_test_i,
  output logic [CNT_W-1:0] count_o,
  output logic [NIB_W-1:0] rd_nib_o,
  output logic             flag_o,
  output logic             irq_o
);
  if (DIV_EXP < 0 || DIV_EXP > 13 || DIV_EXP == 6) begin : g_bad_exp
    $fatal(1, "pscale_timer: DIV_EXP must be 0..13 and not 6");
  end

  tmr_cmd_e         cmd_w;
  logic             tick_w;
  logic             ovf_w;
  logic             run_w;
  logic [CNT_W-1:0] cnt_w;

  assign cmd_w = tmr_cmd_e'(cmd_i);

  pscale_timer_div #(.DIV_EXP(DIV_EXP)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick_w)
  );

  pscale_timer_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_w),
    .cmd_i   (cmd_w),
    .data_i  (data_i),
    .count_o (cnt_w),
    .run_o   (run_w),
    .ovf_o   (ovf_w)
  );

  pscale_timer_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ovf_i  (ovf_w),
    .ack_i  (irq_ack_i),
    .test_i (flag_test_i),
    .flag_o (flag_o),
    .irq_o  (irq_o)
  );

  assign count_o  = cnt_w;
  assign rd_nib_o = rd_hi_i ? cnt_w[CNT_W-1:NIB_W] : cnt_w[NIB_W-1:0];
endmodule

// File: rtl/pscale_timer_chk.sv
module pscale_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       cmd_i,
  input logic             irq_ack_i,
  input logic             flag_test_i,
  input logic [CNT_W-1:0] count_o,
  input logic             flag_o,
  input logic             irq_o,
  input logic             tick_w,
  input logic             ovf_w,
  input logic             run_w
);
  // R5, R8: overflow always leaves the flag set
  assert_wrap_sets_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_w |=> (flag_o && irq_o));

  assert_irq_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  assert_ack_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && !ovf_w) |=> !flag_o);

  assert_test_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_test_i && !ovf_w) |=> !flag_o);

  // R2, R3: count moves only on a tick or a load
  assert_count_moves_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o != $past(count_o)) |-> ($past(tick_w) || $past(cmd_i) == 3'd1));

  // R4: overflow needs a running counter
  assert_ovf_needs_run_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_w |-> run_w);
endmodule

bind pscale_timer pscale_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_i       (cmd_i),
  .irq_ack_i   (irq_ack_i),
  .flag_test_i (flag_test_i),
  .count_o     (count_o),
  .flag_o      (flag_o),
  .irq_o       (irq_o),
  .tick_w      (tick_w),
  .ovf_w       (ovf_w),
  .run_w       (run_w)
);

// File: tb/pscale_timer_test.sv
`timescale 1ns/1ps
module pscale_timer_test;
  localparam int DIV = 2;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] cmd_i = 3'd0;
  logic [7:0] data_i = 8'h00;
  logic       rd_hi_i = 1'b0;
  logic       irq_ack_i = 1'b0;
  logic       flag_test_i = 1'b0;
  logic [7:0] count_o;
  logic [3:0] rd_nib_o;
  logic       flag_o, irq_o;

  int n_chk = 0;
  int n_fail = 0;
  string phase = "R1";

  always #2 clk_i = ~clk_i;

  pscale_timer #(.DIV_EXP(DIV)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd_i), .data_i(data_i),
    .rd_hi_i(rd_hi_i), .irq_ack_i(irq_ack_i), .flag_test_i(flag_test_i),
    .count_o(count_o), .rd_nib_o(rd_nib_o), .flag_o(flag_o), .irq_o(irq_o)
  );

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // reference model built from the requirements
  logic [DIV-1:0] m_pre;
  logic [7:0] m_cnt;
  logic m_run, m_flag, m_irq, m_plv, m_phv;
  logic [3:0] m_pl, m_ph;
  logic [7:0] q_c[$];
  logic       q_f[$];
  logic       q_i[$];
  string      q_t[$];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pre = '0; m_cnt = 8'h00; m_run = 0; m_flag = 0; m_irq = 0;
      m_plv = 0; m_phv = 0; m_pl = 0; m_ph = 0;
      q_c.delete(); q_f.delete(); q_i.delete(); q_t.delete();
    end else begin
      logic tick, ovf, run_old;
      tick = (m_pre == '1);
      m_pre = m_pre + 1'b1;
      run_old = m_run;
      ovf = 0;
      if (cmd_i == 3'd2) m_run = 1;
      if (cmd_i == 3'd3) m_run = 0;
      if (cmd_i == 3'd1) begin
        m_cnt = data_i; m_plv = 0; m_phv = 0;
      end else begin
        if (tick && (m_plv || m_phv)) begin
          if (m_plv) m_cnt[3:0] = m_pl;
          if (m_phv) m_cnt[7:4] = m_ph;
          m_plv = 0; m_phv = 0;
        end else if (tick && run_old) begin
          ovf = (m_cnt == 8'hFF);
          m_cnt = m_cnt + 1'b1;
        end
        if (cmd_i == 3'd4) begin m_plv = 1; m_pl = data_i[3:0]; end
        if (cmd_i == 3'd5) begin m_phv = 1; m_ph = data_i[3:0]; end
      end
      m_irq = ovf;
      if (ovf) m_flag = 1;
      else if (irq_ack_i || flag_test_i) m_flag = 0;
      q_c.push_back(m_cnt); q_f.push_back(m_flag);
      q_i.push_back(m_irq); q_t.push_back(phase);
    end
  end

  // monitor: compare just after each edge
  always @(posedge clk_i) begin
    #1;
    if (rst_ni && q_c.size() > 0) begin
      logic [7:0] ec; logic ef, ei; string t;
      ec = q_c.pop_front(); ef = q_f.pop_front();
      ei = q_i.pop_front(); t = q_t.pop_front();
      chk({t, " count"}, count_o, ec);
      chk({t, " flag"}, flag_o, ef);
      chk({t, " irq"}, irq_o, ei);
      chk("R9 nibble read", rd_nib_o, rd_hi_i ? ec[7:4] : ec[3:0]);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic cmd(logic [2:0] c, logic [7:0] d);
    @(negedge clk_i);
    cmd_i = c; data_i = d;
    @(negedge clk_i);
    cmd_i = 3'd0;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle(2);
    // R1 during reset
    chk("R1 reset count", count_o, 0);
    chk("R1 reset flag", flag_o, 0);
    chk("R1 reset irq", irq_o, 0);
    rst_ni = 1'b1;
    phase = "R1 stopped after reset";
    idle(6);
    phase = "R3 load"; cmd(3'd1, 8'hA5);
    phase = "R4 stopped hold"; idle(7);
    phase = "R2 count"; cmd(3'd2, 8'h00); idle(21);
    phase = "R4 stop"; cmd(3'd3, 8'h00); idle(9);
    phase = "R9 read";
    for (int k = 0; k < 6; k++) begin @(negedge clk_i); rd_hi_i = ~rd_hi_i; end
    phase = "R10 write low stopped"; cmd(3'd4, 8'h03); idle(6);
    phase = "R10 write high running"; cmd(3'd5, 8'h0C); cmd(3'd2, 8'h00); idle(10);
    cmd(3'd4, 8'h09); idle(9);
    cmd(3'd3, 8'h00);
    phase = "R3 load cancels pending"; cmd(3'd5, 8'h01); cmd(3'd1, 8'h20); idle(9);
    phase = "R11 ignored codes"; cmd(3'd6, 8'hFF); cmd(3'd7, 8'h77); cmd(3'd0, 8'h55); idle(6);
    phase = "R5 wrap"; cmd(3'd1, 8'hFD); cmd(3'd2, 8'h00); idle(20);
    phase = "R6 ack";
    @(negedge clk_i); irq_ack_i = 1; @(negedge clk_i); irq_ack_i = 0; idle(4);
    phase = "R7 test"; cmd(3'd1, 8'hFE); idle(12);
    @(negedge clk_i); flag_test_i = 1; @(negedge clk_i); flag_test_i = 0; idle(4);
    phase = "R8 clear with overflow";
    cmd(3'd1, 8'hFC); @(negedge clk_i); irq_ack_i = 1; idle(24); irq_ack_i = 0;
    flag_test_i = 1; idle(3); flag_test_i = 0;
    phase = "R2 long run"; cmd(3'd1, 8'h00); idle(1040);
    cmd(3'd3, 8'h00); idle(4);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule